// File: doc/BRIEF.md
# Bus-Control Port with Per-Pin Alternate Functions

This block is the register side of an eight-pin microcontroller port that is shared with external-bus control signals. Software reaches four byte-wide registers over a simple register bus:
- a data latch;
- a direction register;
- a function-assignment register;
- a single pull-enable control bit.

Each pin is driven either by general-purpose data or by an alternate bus-control function. The assignment register makes that choice separately for every pin. The two lowest pins can only be inputs.

The block also watches the operating mode. In peripheral-test mode, or in an expanded mode with external emulation enabled, the data latch is removed from the on-chip map. An access to it then raises a one-cycle external strobe so the surrounding bus logic can forward the access off chip, and the internal state is left untouched.

Register offsets:

| Offset | Register |
|---|---|
| 0 | Data |
| 1 | Direction |
| 2 | Assignment |
| 3 | Control (pull enable in bit 0) |
| 4 to 7 | Reserved |

A write takes one clock. Read data is combinational.

Top module: `gpio_altfn_port`

## Requirements
- R1: After reset, data bits 7..2 read as 0, direction reads 0x00, assignment reads 0xFF (every pin on its alternate function) and control reads 0x00. Data bits 1..0 keep their previous value through reset.
- R2: Direction bits 7..2 are written and read back at offset 1. Direction bits 1..0 ignore writes and always read 0.
- R3: A read of offset 0 returns, for each bit, the data latch when that bit's direction is 1 and the level on `pin_in` when it is 0.
- R4: When a pin's assignment bit is 1, `pad_out`/`pad_oe` follow `alt_out`/`alt_oe`. When it is 0, they follow the data latch and the direction bit.
- R5: Pins 1 and 0 are never driven: `pad_oe[1:0]` and `pad_out[1:0]` are always 0.
- R6: A pin has `pad_pull_en` set exactly when control bit 0 is 1, the pin is pull-capable (mask 0x9F: pins 7, 4, 3, 2, 1, 0) and its `pad_oe` is 0.
- R7: The data latch is unmapped when `mode_periph` is 1, or when `mode_expanded` and `emul_en` are both 1. In that state an access to offset 0 raises `ext_req` in the same cycle, reads 0 and writes nothing.
- R8: Offsets 4..7 read as 0 and ignore writes. Control bits 7..1 read 0.
- R9: `ext_req` stays 0 for every access other than one to an unmapped data latch. Reads with `bus_sel` low return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| ext_req | output | 1 | Access forwarded to the external bus |
| mode_periph | input | 1 | Peripheral-test mode |
| mode_expanded | input | 1 | Expanded bus mode |
| emul_en | input | 1 | External emulation enable |
| pin_in | input | 8 | Pad input levels |
| alt_out | input | 8 | Alternate-function output values |
| alt_oe | input | 8 | Alternate-function output enables |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pull_en | output | 8 | Pull-device enables |

## Verification
The assertions check on every cycle that the input-only pins are never driven and that no pull is ever enabled on a driven pin. They also check that the direction bits of the input-only pins stay 0 and that reserved and unmapped reads return 0. A further assertion checks that a forwarded write leaves the data latch untouched.

The per-bit choice of read source and the switch between alternate and general-purpose drive need the bench. So do the reset values, the decoding of the mode combinations and the retention of data across mode changes. The bench shows these by comparing read-back and pad outputs against a shadow model under random and directed sequences.

// File: rtl/gpio_altfn_pkg.sv
package gpio_altfn_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFF_DATA = 3'd0,
    OFF_DIR  = 3'd1,
    OFF_ASG  = 3'd2,
    OFF_CTL  = 3'd3
  } reg_off_e;
endpackage

// File: rtl/gpio_altfn_decode.sv
module gpio_altfn_decode
  import gpio_altfn_pkg::*;
#(
  parameter int unsigned W = PORT_W
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              mode_periph,
  input  logic              mode_expanded,
  input  logic              emul_en,
  input  logic [W-1:0]      data_q,
  input  logic [W-1:0]      dir_q,
  input  logic [W-1:0]      asg_q,
  input  logic              pull_q,
  input  logic [W-1:0]      pin_in,
  output logic              wr_data_en,
  output logic              wr_dir_en,
  output logic              wr_asg_en,
  output logic              wr_ctl_en,
  output logic              ext_req,
  output logic [W-1:0]      bus_rdata
);
  logic unmapped;
  logic hit_data, hit_dir, hit_asg, hit_ctl;

  always_comb begin
    unmapped   = mode_periph | (mode_expanded & emul_en);
    hit_data   = bus_sel && (bus_addr == OFF_DATA);
    hit_dir    = bus_sel && (bus_addr == OFF_DIR);
    hit_asg    = bus_sel && (bus_addr == OFF_ASG);
    hit_ctl    = bus_sel && (bus_addr == OFF_CTL);
    wr_data_en = hit_data & bus_wr & ~unmapped;
    wr_dir_en  = hit_dir & bus_wr;
    wr_asg_en  = hit_asg & bus_wr;
    wr_ctl_en  = hit_ctl & bus_wr;
    ext_req    = hit_data & unmapped;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_data && !unmapped) bus_rdata = (dir_q & data_q) | (~dir_q & pin_in);
    else if (hit_dir)          bus_rdata = dir_q;
    else if (hit_asg)          bus_rdata = asg_q;
    else if (hit_ctl)          bus_rdata = {{(W-1){1'b0}}, pull_q};
  end
endmodule

// File: rtl/gpio_altfn_regs.sv
module gpio_altfn_regs
  import gpio_altfn_pkg::*;
#(
  parameter int unsigned W       = PORT_W,
  parameter logic [W-1:0] IN_ONLY = 8'h03
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data_en,
  input  logic         wr_dir_en,
  input  logic         wr_asg_en,
  input  logic         wr_ctl_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] asg_q,
  output logic         pull_q
);
  logic [W-1:0] dir_d, asg_d;
  logic         pull_d;

  always_comb begin
    dir_d  = wr_dir_en ? (wdata & ~IN_ONLY) : dir_q;
    asg_d  = wr_asg_en ? wdata : asg_q;
    pull_d = wr_ctl_en ? wdata[0] : pull_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      asg_q  <= '1;
      pull_q <= 1'b0;
    end else begin
      dir_q  <= dir_d;
      asg_q  <= asg_d;
      pull_q <= pull_d;
    end
  end

  // Data latch: input-only bits keep their value through reset.
  for (genvar i = 0; i < W; i++) begin : g_data
    logic bit_q;
    if (IN_ONLY[i]) begin : g_keep
      always_ff @(posedge clk) begin
        if (wr_data_en) bit_q <= wdata[i];
      end
    end else begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          bit_q <= 1'b0;
        else if (wr_data_en) bit_q <= wdata[i];
      end
    end
    assign data_q[i] = bit_q;
  end
endmodule

// File: rtl/gpio_altfn_pinmux.sv
module gpio_altfn_pinmux
  import gpio_altfn_pkg::*;
#(
  parameter int unsigned  W         = PORT_W,
  parameter logic [W-1:0] IN_ONLY   = 8'h03,
  parameter logic [W-1:0] PULL_MASK = 8'h9F
) (
  input  logic [W-1:0] data_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] asg_q,
  input  logic         pull_q,
  input  logic [W-1:0] alt_out,
  input  logic [W-1:0] alt_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pull_en
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    if (IN_ONLY[i]) begin : g_in
      assign pad_out[i] = 1'b0;
      assign pad_oe[i]  = 1'b0;
    end else begin : g_io
      assign pad_out[i] = asg_q[i] ? alt_out[i] : data_q[i];
      assign pad_oe[i]  = asg_q[i] ? alt_oe[i]  : dir_q[i];
    end
    if (PULL_MASK[i]) begin : g_pull
      assign pad_pull_en[i] = pull_q & ~pad_oe[i];
    end else begin : g_nopull
      assign pad_pull_en[i] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_altfn_port.sv
module gpio_altfn_port
  import gpio_altfn_pkg::*;
#(
  parameter int unsigned  W         = PORT_W,
  parameter logic [W-1:0] IN_ONLY   = 8'h03,
  parameter logic [W-1:0] PULL_MASK = 8'h9F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              ext_req,
  input  logic              mode_periph,
  input  logic              mode_expanded,
  input  logic              emul_en,
  input  logic [W-1:0]      pin_in,
  input  logic [W-1:0]      alt_out,
  input  logic [W-1:0]      alt_oe,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_pull_en
);
  logic [1:0]   rst_sync_q;
  logic         rst_n_int;
  logic [W-1:0] data_q, dir_q, asg_q;
  logic         pull_q;
  logic         wr_data_en, wr_dir_en, wr_asg_en, wr_ctl_en;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  gpio_altfn_decode #(.W(W)) decode_i (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .mode_periph(mode_periph), .mode_expanded(mode_expanded), .emul_en(emul_en),
    .data_q(data_q), .dir_q(dir_q), .asg_q(asg_q), .pull_q(pull_q), .pin_in(pin_in),
    .wr_data_en(wr_data_en), .wr_dir_en(wr_dir_en), .wr_asg_en(wr_asg_en),
    .wr_ctl_en(wr_ctl_en), .ext_req(ext_req), .bus_rdata(bus_rdata)
  );

  gpio_altfn_regs #(.W(W), .IN_ONLY(IN_ONLY)) regs_i (
    .clk(clk), .rst_n(rst_n_int),
    .wr_data_en(wr_data_en), .wr_dir_en(wr_dir_en), .wr_asg_en(wr_asg_en),
    .wr_ctl_en(wr_ctl_en), .wdata(bus_wdata),
    .data_q(data_q), .dir_q(dir_q), .asg_q(asg_q), .pull_q(pull_q)
  );

  gpio_altfn_pinmux #(.W(W), .IN_ONLY(IN_ONLY), .PULL_MASK(PULL_MASK)) pinmux_i (
    .data_q(data_q), .dir_q(dir_q), .asg_q(asg_q), .pull_q(pull_q),
    .alt_out(alt_out), .alt_oe(alt_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en)
  );
endmodule

// File: rtl/gpio_altfn_port_chk.sv
module gpio_altfn_port_chk
  import gpio_altfn_pkg::*;
#(
  parameter int unsigned  W       = PORT_W,
  parameter logic [W-1:0] IN_ONLY = 8'h03
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_rdata,
  input logic              ext_req,
  input logic [W-1:0]      pad_oe,
  input logic [W-1:0]      pad_out,
  input logic [W-1:0]      pad_pull_en,
  input logic [W-1:0]      data_q,
  input logic [W-1:0]      dir_q
);
  // R5
  in_only_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & IN_ONLY) == '0) && ((pad_out & IN_ONLY) == '0));

  // R6
  no_pull_on_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pull_en & pad_oe) == '0);

  // R2
  in_only_dir_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q & IN_ONLY) == '0);

  // R7
  ext_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> (bus_rdata == '0));

  // R7
  ext_write_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && bus_wr) |=> $stable(data_q));

  // R9
  ext_only_data_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> (bus_sel && bus_addr == OFF_DATA));

  // R8
  reserved_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel || bus_addr > OFF_CTL) |-> (bus_rdata == '0));
endmodule

bind gpio_altfn_port gpio_altfn_port_chk #(.W(W), .IN_ONLY(IN_ONLY)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .ext_req(ext_req), .pad_oe(pad_oe), .pad_out(pad_out),
  .pad_pull_en(pad_pull_en), .data_q(data_q), .dir_q(dir_q)
);

// File: tb/gpio_altfn_port_tb.sv
module gpio_altfn_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       ext_req;
  logic       mode_periph = 1'b0, mode_expanded = 1'b0, emul_en = 1'b0;
  logic [7:0] pin_in = '0, alt_out = '0, alt_oe = '0;
  logic [7:0] pad_out, pad_oe, pad_pull_en;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_data = '0, m_dir = '0, m_asg = 8'hFF;
  logic       m_pull = 1'b0;
  localparam logic [7:0] PULLM = 8'h9F;
  localparam logic [7:0] IO_M  = 8'hFC;

  always #4 clk = ~clk;

  gpio_altfn_port dut_i (.*);

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  function automatic logic unmapped_f();
    return mode_periph | (mode_expanded & emul_en);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return unmapped_f() ? 8'h00 : ((m_dir & m_data) | (~m_dir & pin_in));
      3'd1: return m_dir;
      3'd2: return m_asg;
      3'd3: return {7'b0, m_pull};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_oe();
    return ((m_asg & alt_oe) | (~m_asg & m_dir)) & IO_M;
  endfunction

  function automatic logic [7:0] exp_out();
    return ((m_asg & alt_out) | (~m_asg & m_data)) & IO_M;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1;
    chk("R7/R9 ext_req on write", {7'b0, ext_req}, {7'b0, (a == 3'd0) && unmapped_f()});
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    case (a)
      3'd0: if (!unmapped_f()) m_data = d;
      3'd1: m_dir = d & IO_M;
      3'd2: m_asg = d;
      3'd3: m_pull = d[0];
      default: ;
    endcase
  endtask

  task automatic rd(input string tag, input logic [2:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp_rd(a));
    chk("R7/R9 ext_req on read", {7'b0, ext_req}, {7'b0, (a == 3'd0) && unmapped_f()});
    bus_sel = 1'b0;
  endtask

  task automatic pads(input string tag);
    #1;
    chk({tag, " R4 oe"}, pad_oe, exp_oe());
    chk({tag, " R4/R5 out"}, pad_out, exp_out());
    chk({tag, " R6 pull"}, pad_pull_en, {8{m_pull}} & PULLM & ~exp_oe());
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    pin_in = 8'hA5;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1: reset values
    rd("R1 dir reset", 3'd1);
    rd("R1 asg reset", 3'd2);
    rd("R1 ctl reset", 3'd3);
    pads("R1");
    wr(3'd1, 8'hFF);
    rd("R2 dir bits1:0 ignored", 3'd1);
    pin_in = 8'h00;
    @(negedge clk); bus_sel = 1'b1; bus_addr = 3'd0; #1;
    chk("R1 data[7:2] reset clear", bus_rdata & IO_M, 8'h00);
    bus_sel = 1'b0;
    // R3: mixed direction read source
    wr(3'd0, 8'h3C); wr(3'd1, 8'hF0); pin_in = 8'h5A;
    rd("R3 mixed source", 3'd0);
    // R4: GP drive then alternate drive
    wr(3'd2, 8'h00); alt_out = 8'hFF; alt_oe = 8'hFF;
    pads("R4 gp");
    wr(3'd2, 8'hFF);
    pads("R4 alt");
    // R6: pulls on inputs
    wr(3'd3, 8'hFF); alt_oe = 8'h0C;
    pads("R6 pull");
    rd("R8 ctl high bits", 3'd3);
    // R8: reserved
    wr(3'd5, 8'hFF);
    rd("R8 reserved 5", 3'd5);
    rd("R8 reserved 7", 3'd7);
    // R7: each unmapped combination, writes ignored
    wr(3'd1, 8'hFC); wr(3'd0, 8'h44);
    mode_periph = 1'b1; wr(3'd0, 8'hBB); rd("R7 periph read", 3'd0);
    mode_periph = 1'b0; mode_expanded = 1'b1; emul_en = 1'b1;
    wr(3'd0, 8'hCC); rd("R7 exp+emul read", 3'd0);
    emul_en = 1'b0; rd("R7 expanded only mapped", 3'd0);
    mode_expanded = 1'b0; rd("R7 data kept", 3'd0);
    // R9: idle read returns zero
    @(negedge clk); bus_addr = 3'd1; #1;
    chk("R9 idle rdata", bus_rdata, 8'h00);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] a;
      a = 3'($urandom_range(0, 7));
      mode_periph   = ($urandom_range(0, 3) == 0);
      mode_expanded = $urandom_range(0, 1) == 1;
      emul_en       = $urandom_range(0, 1) == 1;
      pin_in  = 8'($urandom); alt_out = 8'($urandom); alt_oe = 8'($urandom);
      if ($urandom_range(0, 1) == 1) wr(a, 8'($urandom));
      rd("R2/R3/R8 random read", 3'($urandom_range(0, 7)));
      pads("random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule